// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sits beside a processor core and decides which pending exception the core takes, then performs the register bookkeeping of entry in one clock. Seven request lines arrive together with the core's current program counter and status word. The block picks the highest-ranking request that is not masked. It stores the interrupted program counter and the interrupted status word in a register pair that belongs only to the target exception mode. It then hands the core a new program counter and a new status word.

The new program counter is a fixed vector per exception type. The new status word has its mode field rewritten, the instruction-set state bit cleared and the interrupt mask bits updated. A return strobe does the reverse. It reads the register pair of the mode the core is currently in and hands back the saved program counter and status word, so the interrupted code resumes where it stopped.

The status word layout used throughout is: bits 4..0 mode field, bit 5 instruction-set state bit (1 = 16-bit state), bit 6 fast-interrupt mask, bit 7 normal-interrupt mask. Bits above 7 pass through untouched. Banked register pairs are indexed 0 supervisor, 1 abort, 2 undefined, 3 normal interrupt, 4 fast interrupt.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Among the requests that are not masked, exactly one is accepted per cycle. The ranking, highest first, is: reset request, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R2: A normal interrupt request is ignored while status bit 7 is 1. A fast interrupt request is ignored while status bit 6 is 1. An ignored request produces no entry and leaves every banked register unchanged.
- R3: On entry, the incoming status word is written into the saved-status register of the target mode. The saved-status and link registers of every other mode keep their values.
- R4: On entry, the new status word carries the mode code of the target mode. Reset request and software interrupt go to supervisor 10011. Both aborts go to abort 10111. Undefined instruction goes to undefined 11011. Normal interrupt goes to 10010. Fast interrupt goes to 10001.
- R5: On entry, the new status word has bit 5 cleared and bit 7 set. Bit 6 is set for reset request and fast interrupt and is otherwise copied from the incoming status word. All bits above 7 are copied unchanged.
- R6: On entry, the incoming program counter is written into the link register of the target mode.
- R7: On entry, the new program counter is VEC_BASE plus the byte offset of the exception. The offsets are: reset 0x00, undefined 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R8: When the return strobe is high and no request is accepted in the same cycle, and the current mode field names one of the five banked modes, the block pulses ret_vld one cycle later. It then outputs that mode's link register as new_pc and that mode's saved status as new_psr. In any other mode the strobe produces no pulse. Entry and return pulses never occur together.
- R9: An accepted request pulses entry_vld high for exactly the next cycle, with new_pc, new_psr and the banked registers already updated in that cycle. With no accepted request, entry_vld is low.
- R10: An active-low asynchronous reset immediately forces entry_vld and ret_vld low, new_pc to 0, new_psr to 0xD3 (supervisor, both masks set, bit 5 clear) and all banked registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| ret_req | input | 1 | Return-from-exception strobe |
| cur_pc | input | ADDR_W | Core's current program counter |
| cur_psr | input | PSR_W | Core's current status word |
| entry_vld | output | 1 | Entry performed in this cycle |
| ret_vld | output | 1 | Return performed in this cycle |
| new_pc | output | ADDR_W | Program counter for the core to load |
| new_psr | output | PSR_W | Status word for the core to load |
| bank_lr | output | 5 x ADDR_W | Link registers, one per banked mode |
| bank_spsr | output | 5 x PSR_W | Saved-status registers, one per banked mode |

## Verification
The hardest case is a nested exception. The core is already inside one exception mode and is entered into a second one. It then returns twice, and each return must restore its own level without the inner entry having disturbed the outer mode's saved pair. The bench acts as the core: after every pulse it loads new_pc and new_psr back into cur_pc and cur_psr. Entries and returns therefore chain naturally under random requests. A directed sequence forces user, then normal interrupt, then fast interrupt, then return, then return.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int MODE_W = 5;
  localparam int T_BIT  = 5;
  localparam int F_BIT  = 6;
  localparam int I_BIT  = 7;
  localparam int NBANK  = 5;
  localparam int NREQ   = 7;
  localparam int BIDX_W = $clog2(NBANK);

  localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

  // rank order: lower value wins
  typedef enum logic [2:0] {
    EK_RST  = 3'd0,
    EK_DABT = 3'd1,
    EK_FIQ  = 3'd2,
    EK_IRQ  = 3'd3,
    EK_PABT = 3'd4,
    EK_UND  = 3'd5,
    EK_SWI  = 3'd6,
    EK_NONE = 3'd7
  } exc_kind_e;

  function automatic logic [MODE_W-1:0] kind_mode(exc_kind_e k);
    case (k)
      EK_DABT, EK_PABT: return MD_ABT;
      EK_FIQ:           return MD_FIQ;
      EK_IRQ:           return MD_IRQ;
      EK_UND:           return MD_UND;
      default:          return MD_SVC;
    endcase
  endfunction

  function automatic logic [7:0] kind_offset(exc_kind_e k);
    case (k)
      EK_UND:  return 8'h04;
      EK_SWI:  return 8'h08;
      EK_PABT: return 8'h0C;
      EK_DABT: return 8'h10;
      EK_IRQ:  return 8'h18;
      EK_FIQ:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic kind_sets_f(exc_kind_e k);
    return (k == EK_RST) || (k == EK_FIQ);
  endfunction

  function automatic logic mode_banked(logic [MODE_W-1:0] m);
    return (m == MD_SVC) || (m == MD_ABT) || (m == MD_UND) ||
           (m == MD_IRQ) || (m == MD_FIQ);
  endfunction

  function automatic logic [BIDX_W-1:0] mode_bank(logic [MODE_W-1:0] m);
    case (m)
      MD_ABT:  return BIDX_W'(1);
      MD_UND:  return BIDX_W'(2);
      MD_IRQ:  return BIDX_W'(3);
      MD_FIQ:  return BIDX_W'(4);
      default: return BIDX_W'(0);
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic [NREQ-1:0] req,
  input  logic            mask_i,
  input  logic            mask_f,
  output logic            take,
  output exc_kind_e       kind
);

  logic [NREQ-1:0] eff;

  always_comb begin
    eff = req;
    eff[EK_FIQ] = req[EK_FIQ] & ~mask_f;
    eff[EK_IRQ] = req[EK_IRQ] & ~mask_i;
  end

  always_comb begin
    kind = EK_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (eff[i]) kind = exc_kind_e'(i);
    end
  end

  assign take = |eff;

endmodule

// File: rtl/exc_bank.sv
module exc_bank
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NBANK-1:0]                wr_sel,
  input  logic [ADDR_W-1:0]               wr_lr,
  input  logic [PSR_W-1:0]                wr_spsr,
  output logic [NBANK-1:0][ADDR_W-1:0]    lr_q,
  output logic [NBANK-1:0][PSR_W-1:0]     spsr_q
);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lr_q[b]   <= '0;
        spsr_q[b] <= '0;
      end else if (wr_sel[b]) begin
        lr_q[b]   <= wr_lr;
        spsr_q[b] <= wr_spsr;
      end
    end
  end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  exc_kind_e         kind,
  input  logic              ret_take,
  input  logic [ADDR_W-1:0] ret_lr,
  input  logic [PSR_W-1:0]  ret_spsr,
  input  logic [PSR_W-1:0]  cur_psr,
  output logic              entry_vld,
  output logic              ret_vld,
  output logic [ADDR_W-1:0] new_pc,
  output logic [PSR_W-1:0]  new_psr
);

  localparam logic [PSR_W-1:0] PSR_RESET =
    PSR_W'({1'b1, 1'b1, 1'b0, MD_SVC});

  function automatic logic [PSR_W-1:0] entry_psr(logic [PSR_W-1:0] p,
                                                 exc_kind_e k);
    logic [PSR_W-1:0] r;
    r = p;
    r[MODE_W-1:0] = kind_mode(k);
    r[T_BIT] = 1'b0;
    r[I_BIT] = 1'b1;
    if (kind_sets_f(k)) r[F_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] entry_pc(exc_kind_e k);
    return VEC_BASE + ADDR_W'(kind_offset(k));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_vld <= 1'b0;
      ret_vld   <= 1'b0;
      new_pc    <= '0;
      new_psr   <= PSR_RESET;
    end else begin
      entry_vld <= take;
      ret_vld   <= ret_take;
      if (take) begin
        new_pc  <= entry_pc(kind);
        new_psr <= entry_psr(cur_psr, kind);
      end else if (ret_take) begin
        new_pc  <= ret_lr;
        new_psr <= ret_spsr;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_rst,
  input  logic                         req_dabt,
  input  logic                         req_fiq,
  input  logic                         req_irq,
  input  logic                         req_pabt,
  input  logic                         req_und,
  input  logic                         req_swi,
  input  logic                         ret_req,
  input  logic [ADDR_W-1:0]            cur_pc,
  input  logic [PSR_W-1:0]             cur_psr,
  output logic                         entry_vld,
  output logic                         ret_vld,
  output logic [ADDR_W-1:0]            new_pc,
  output logic [PSR_W-1:0]             new_psr,
  output logic [NBANK-1:0][ADDR_W-1:0] bank_lr,
  output logic [NBANK-1:0][PSR_W-1:0]  bank_spsr
);

  logic [NREQ-1:0]   req_vec;
  logic              take_w;
  exc_kind_e         kind_w;
  logic              ret_ok_w;
  logic              ret_take_w;
  logic [BIDX_W-1:0] ret_idx_w;
  logic [NBANK-1:0]  wr_sel_w;

  assign req_vec = {req_swi, req_und, req_pabt, req_irq,
                    req_fiq, req_dabt, req_rst};

  exc_prio_arb u_arb (
    .req    (req_vec),
    .mask_i (cur_psr[I_BIT]),
    .mask_f (cur_psr[F_BIT]),
    .take   (take_w),
    .kind   (kind_w)
  );

  always_comb begin
    wr_sel_w = '0;
    if (take_w) wr_sel_w[mode_bank(kind_mode(kind_w))] = 1'b1;
  end

  assign ret_ok_w   = mode_banked(cur_psr[MODE_W-1:0]);
  assign ret_idx_w  = mode_bank(cur_psr[MODE_W-1:0]);
  assign ret_take_w = ret_req && !take_w && ret_ok_w;

  exc_bank #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (wr_sel_w),
    .wr_lr   (cur_pc),
    .wr_spsr (cur_psr),
    .lr_q    (bank_lr),
    .spsr_q  (bank_spsr)
  );

  exc_seq #(.ADDR_W(ADDR_W), .PSR_W(PSR_W), .VEC_BASE(VEC_BASE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_w),
    .kind      (kind_w),
    .ret_take  (ret_take_w),
    .ret_lr    (bank_lr[ret_idx_w]),
    .ret_spsr  (bank_spsr[ret_idx_w]),
    .cur_psr   (cur_psr),
    .entry_vld (entry_vld),
    .ret_vld   (ret_vld),
    .new_pc    (new_pc),
    .new_psr   (new_psr)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PSR_W  = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_rst,
  input logic                         req_dabt,
  input logic                         req_fiq,
  input logic                         req_irq,
  input logic                         req_pabt,
  input logic                         req_und,
  input logic                         req_swi,
  input logic [ADDR_W-1:0]            cur_pc,
  input logic [PSR_W-1:0]             cur_psr,
  input logic                         entry_vld,
  input logic                         ret_vld,
  input logic [ADDR_W-1:0]            new_pc,
  input logic [PSR_W-1:0]             new_psr,
  input logic [NBANK-1:0][ADDR_W-1:0] bank_lr,
  input logic [NBANK-1:0][PSR_W-1:0]  bank_spsr
);

  logic [BIDX_W-1:0] new_idx;
  logic [PSR_W-1:0]  spsr_of_cur;
  logic [ADDR_W-1:0] lr_of_cur;
  logic              irq_alone;

  assign new_idx     = mode_bank(new_psr[MODE_W-1:0]);
  assign spsr_of_cur = bank_spsr[mode_bank(cur_psr[MODE_W-1:0])];
  assign lr_of_cur   = bank_lr[mode_bank(cur_psr[MODE_W-1:0])];
  assign irq_alone   = req_irq && !req_rst && !req_dabt && !req_fiq &&
                       !req_pabt && !req_und && !req_swi;

  AST_VLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(entry_vld && ret_vld)); // R8

  AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_rst |=> entry_vld && new_pc == VEC_BASE &&
                new_psr[MODE_W-1:0] == MD_SVC); // R1

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_alone && cur_psr[I_BIT]) |=> !entry_vld); // R2

  AST_SPSR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld |-> bank_spsr[new_idx] == $past(cur_psr)); // R3

  AST_ENTRY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld |-> !new_psr[T_BIT] && new_psr[I_BIT]); // R5

  AST_LR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    entry_vld |-> bank_lr[new_idx] == $past(cur_pc)); // R6

  AST_RET_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    ret_vld |-> new_psr == $past(spsr_of_cur) &&
                new_pc == $past(lr_of_cur)); // R8

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .ADDR_W(ADDR_W), .PSR_W(PSR_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_rst(req_rst), .req_dabt(req_dabt),
  .req_fiq(req_fiq), .req_irq(req_irq), .req_pabt(req_pabt),
  .req_und(req_und), .req_swi(req_swi), .cur_pc(cur_pc),
  .cur_psr(cur_psr), .entry_vld(entry_vld), .ret_vld(ret_vld),
  .new_pc(new_pc), .new_psr(new_psr), .bank_lr(bank_lr),
  .bank_spsr(bank_spsr)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;

  localparam int AW = 32;
  localparam int PW = 32;
  localparam int NB = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic r_rst, r_dabt, r_fiq, r_irq, r_pabt, r_und, r_swi, ret;
  logic [AW-1:0] cpc;
  logic [PW-1:0] cpsr;
  logic entry_vld, ret_vld;
  logic [AW-1:0] npc;
  logic [PW-1:0] npsr;
  logic [NB-1:0][AW-1:0] blr;
  logic [NB-1:0][PW-1:0] bspsr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [AW-1:0] m_lr   [NB];
  logic [PW-1:0] m_spsr [NB];
  logic [AW-1:0] m_pc;
  logic [PW-1:0] m_psr;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_rst(r_rst), .req_dabt(r_dabt),
    .req_fiq(r_fiq), .req_irq(r_irq), .req_pabt(r_pabt), .req_und(r_und),
    .req_swi(r_swi), .ret_req(ret), .cur_pc(cpc), .cur_psr(cpsr),
    .entry_vld(entry_vld), .ret_vld(ret_vld), .new_pc(npc), .new_psr(npsr),
    .bank_lr(blr), .bank_spsr(bspsr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // 0 rst 1 dabt 2 fiq 3 irq 4 pabt 5 und 6 swi, 7 none
  function automatic int pick(logic [6:0] r, logic [PW-1:0] p);
    if (r[0]) return 0;
    if (r[1]) return 1;
    if (r[2] && !p[6]) return 2;
    if (r[3] && !p[7]) return 3;
    if (r[4]) return 4;
    if (r[5]) return 5;
    if (r[6]) return 6;
    return 7;
  endfunction

  function automatic logic [4:0] mcode(int k);
    case (k)
      1, 4: return 5'b10111;
      2:    return 5'b10001;
      3:    return 5'b10010;
      5:    return 5'b11011;
      default: return 5'b10011;
    endcase
  endfunction

  function automatic logic [AW-1:0] vec(int k);
    logic [AW-1:0] t [7] = '{32'h00, 32'h10, 32'h1C, 32'h18, 32'h0C, 32'h04, 32'h08};
    return t[k];
  endfunction

  function automatic int bidx(logic [4:0] m);
    case (m)
      5'b10011: return 0;
      5'b10111: return 1;
      5'b11011: return 2;
      5'b10010: return 3;
      5'b10001: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin m_lr[b] = '0; m_spsr[b] = '0; end
    m_pc = '0;
    m_psr = 32'hD3;
  endtask

  task automatic cmp_banks();
    for (int b = 0; b < NB; b++) begin
      chk("R6 link bank", 64'(blr[b]), 64'(m_lr[b]));
      chk("R3 saved-status bank", 64'(bspsr[b]), 64'(m_spsr[b]));
    end
  endtask

  // one operation; entered and left at negedge
  task automatic step(logic [6:0] r, logic rt, string tag);
    int k;
    int bi;
    logic ev, rv;
    {r_swi, r_und, r_pabt, r_irq, r_fiq, r_dabt, r_rst} = r;
    ret = rt;
    k = pick(r, cpsr);
    bi = bidx(cpsr[4:0]);
    ev = (k != 7);
    rv = rt && !ev && (bi >= 0);
    if (ev) begin
      m_lr[bidx(mcode(k))]   = cpc;
      m_spsr[bidx(mcode(k))] = cpsr;
      m_pc  = vec(k);
      m_psr = cpsr;
      m_psr[4:0] = mcode(k);
      m_psr[5] = 1'b0;
      m_psr[7] = 1'b1;
      if (k == 0 || k == 2) m_psr[6] = 1'b1;
    end else if (rv) begin
      m_pc  = m_lr[bi];
      m_psr = m_spsr[bi];
    end
    @(posedge clk);
    @(negedge clk);
    chk({"R9 entry pulse ", tag}, 64'(entry_vld), 64'(ev));
    chk({"R8 return pulse ", tag}, 64'(ret_vld), 64'(rv));
    if (ev || rv) begin
      chk({"R7 new_pc ", tag}, 64'(npc), 64'(m_pc));
      chk({"R4 R5 new_psr ", tag}, 64'(npsr), 64'(m_psr));
    end
    cmp_banks();
    {r_swi, r_und, r_pabt, r_irq, r_fiq, r_dabt, r_rst} = '0;
    ret = 1'b0;
    if (entry_vld || ret_vld) begin
      cpc = npc;
      cpsr = npsr;
    end else begin
      cpc = cpc + 32'd4;
    end
  endtask

  task automatic go_user(logic i, logic f, logic t);
    cpsr = {24'h0, i, f, t, 5'b10000};
  endtask

  initial begin
    int unsigned seed;
    int cyc;
    cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [6:0] rq;
    logic [AW-1:0] keep_lr;
    r_rst = 0; r_dabt = 0; r_fiq = 0; r_irq = 0; r_pabt = 0; r_und = 0;
    r_swi = 0; ret = 0; cpc = 32'h1000; cpsr = 32'h10;
    void'($urandom(32'h5EED_0777));
    model_reset();
    #3;
    // R10 reset state while reset held
    chk("R10 entry_vld", 64'(entry_vld), 64'd0);
    chk("R10 ret_vld", 64'(ret_vld), 64'd0);
    chk("R10 new_pc", 64'(npc), 64'd0);
    chk("R10 new_psr", 64'(npsr), 64'hD3);
    cmp_banks();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 rank directed
    go_user(0, 0, 1); cpc = 32'h2000;
    step(7'b1111111, 0, "R1 all pending");
    chk("R1 reset wins vector", 64'(npc), 64'h00);
    go_user(0, 0, 0);
    step(7'b0000110, 0, "R1 dabt over fiq");
    chk("R1 dabt wins", 64'(npc), 64'h10);
    go_user(0, 0, 0);
    step(7'b0001100, 0, "R1 fiq over irq");
    chk("R1 fiq wins", 64'(npc), 64'h1C);
    go_user(0, 0, 0);
    step(7'b0011000, 0, "R1 irq over pabt");
    chk("R1 irq wins", 64'(npc), 64'h18);
    go_user(0, 0, 0);
    step(7'b0110000, 0, "R1 pabt over und");
    chk("R1 pabt wins", 64'(npc), 64'h0C);
    go_user(0, 0, 0);
    step(7'b1100000, 0, "R1 und over swi");
    chk("R1 und wins", 64'(npc), 64'h04);
    go_user(0, 0, 0);
    step(7'b1000000, 0, "R7 swi");
    chk("R4 swi to supervisor", 64'(npsr[4:0]), 64'h13);

    // R2 masks
    go_user(1, 0, 0);
    step(7'b0001000, 0, "R2 irq masked");
    chk("R2 no entry when masked", 64'(entry_vld), 64'd0);
    go_user(0, 1, 0);
    step(7'b0000100, 0, "R2 fiq masked");
    chk("R2 no entry when masked", 64'(entry_vld), 64'd0);
    go_user(0, 1, 0);
    step(7'b0001100, 0, "R2 fiq masked irq taken");
    chk("R2 irq taken past masked fiq", 64'(npc), 64'h18);

    // R8 return in user mode ignored, and collision with entry
    go_user(0, 0, 0);
    step(7'b0000000, 1, "R8 user return");
    chk("R8 no return in user", 64'(ret_vld), 64'd0);
    step(7'b0001000, 1, "R8 entry beats return");

    // nested: user -> irq -> fiq -> ret -> ret
    go_user(0, 0, 1); cpc = 32'h0000_4444;
    keep_lr = cpc;
    step(7'b0001000, 0, "nest irq");
    cpc = 32'h0000_0200;
    step(7'b0000100, 0, "nest fiq");
    step(7'b0000000, 1, "nest ret fiq");
    chk("R8 back in irq mode", 64'(npsr[4:0]), 64'h12);
    step(7'b0000000, 1, "nest ret irq");
    chk("R8 back to user pc", 64'(npc), 64'(keep_lr));
    chk("R8 user psr restored", 64'(npsr), 64'h30);

    // random phase
    for (int n = 0; n < 2000; n++) begin
      rq = '0;
      for (int b = 0; b < 7; b++) if ($urandom_range(0, 9) == 0) rq[b] = 1'b1;
      if ($urandom_range(0, 3) == 0) rq[0] = 1'b0;
      if ($urandom_range(0, 11) == 0)
        go_user(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)));
      if ($urandom_range(0, 7) == 0) cpsr[31:8] = 24'($urandom);
      step(rq, ($urandom_range(0, 2) == 0), "random");
    end

    // R10 asynchronous reset mid-run
    go_user(0, 0, 0);
    step(7'b0001000, 0, "pre-reset");
    #1 rst_n = 1'b0;
    #0.5;
    model_reset();
    chk("R10 async entry_vld", 64'(entry_vld), 64'd0);
    chk("R10 async new_pc", 64'(npc), 64'd0);
    chk("R10 async new_psr", 64'(npsr), 64'hD3);
    cmp_banks();
    @(negedge clk);
    rst_n = 1'b1;
    cpsr = 32'hD3;
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule